// File: doc/BRIEF.md
# Shared Shift, Rotate and Permute Unit

A purely combinational 32-bit datapath unit that produces the result of logical and arithmetic shifts, shifts that fill with ones, rotates, full bit reversal, byte-order swap and a byte-wise "any bit set" spread. It takes two operands and an operation code and returns one result word in the same cycle. Operand b supplies the shift or rotate distance through its low five bits. Operand a is the data being moved.

All shift and rotate work is done by a single right shifter that is twice the data width. The upper half of the shifter input holds the fill pattern: a second copy of the operand for rotates, the sign bit for arithmetic shifts, all ones for ones-fill shifts, and zeros otherwise. Left-direction operations mirror the operand's bit order before the shifter and mirror the result back afterwards. The bit reversal and byte swap operations reuse the front mirror stage with a distance of zero.

Top module: `ssr_unit`

## Requirements
- R1: The operation code `op_i` selects the function as follows: 0 shift left with zero fill, 1 shift right with zero fill, 2 shift right with sign fill, 3 shift left with ones fill, 4 shift right with ones fill, 5 rotate left, 6 rotate right, 7 bit reversal, 8 byte swap, 9 byte-wise OR spread. Codes 10 to 15 give a result of zero.
- R2: For codes 0 and 1 the bit positions vacated by the shift are zero and the other bits are the shifted operand a.
- R3: For code 2 the vacated high positions copy bit 31 of operand a.
- R4: For codes 3 and 4 the vacated positions are one and the other bits are the shifted operand a.
- R5: For codes 5 and 6 the bits that leave one end of operand a re-enter at the other end, so no bit is lost.
- R6: The distance is b_i[4:0], and bits 31:5 of b_i have no effect on any result. A distance of zero returns operand a unchanged for codes 0 to 6.
- R7: Code 7 returns operand a with bit i moved to bit 31-i, for every i. Operand b has no effect.
- R8: Code 8 returns operand a with byte 0 and byte 3 swapped and byte 1 and byte 2 swapped. The bits inside each byte keep their order.
- R9: Code 9 sets each result byte to 0xFF when the matching byte of operand a has any bit set, and to 0x00 when that byte is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | Data operand |
| b_i | input | 32 | Distance operand; only bits 4:0 are used |
| op_i | input | 4 | Operation code, encoded as listed in R1 |
| result_o | output | 32 | Result of the selected operation |

## Verification
Every operation code is swept over all 32 distances. Each distance is tried with several operand patterns:
- All-zero and all-one words show zero fill apart from ones fill.
- A single set high bit and a single set low bit mark the exact distance and direction of movement.
- Words with bit 31 set and words with bit 31 clear separate sign fill from zero fill.
- Irregular mixed words, produced by a shift-register sequence, expose wrong wrap-around in rotates and wrong byte placement in the swap and spread operations.

The upper bits of operand b are loaded with varying junk throughout the sweep, to show that they have no effect.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_SLL  = 4'd0,
    OP_SRL  = 4'd1,
    OP_SRA  = 4'd2,
    OP_SLO  = 4'd3,
    OP_SRO  = 4'd4,
    OP_ROL  = 4'd5,
    OP_ROR  = 4'd6,
    OP_REV  = 4'd7,
    OP_REV8 = 4'd8,
    OP_ORCB = 4'd9
  } ssr_op_e;

  typedef enum logic [1:0] {
    FILL_ZERO,
    FILL_ONES,
    FILL_SIGN,
    FILL_COPY
  } ssr_fill_e;

  // Operations that run the right shifter on a mirrored operand
  function automatic logic op_is_left(ssr_op_e op);
    return (op == OP_SLL) || (op == OP_SLO) || (op == OP_ROL);
  endfunction

  // Operations whose distance comes from operand b
  function automatic logic op_uses_amt(ssr_op_e op);
    return (op == OP_SLL) || (op == OP_SRL) || (op == OP_SRA) ||
           (op == OP_SLO) || (op == OP_SRO) || (op == OP_ROL) ||
           (op == OP_ROR);
  endfunction

  // What the upper half of the wide shifter is loaded with
  function automatic ssr_fill_e op_fill(ssr_op_e op);
    case (op)
      OP_SRA:         return FILL_SIGN;
      OP_SLO, OP_SRO: return FILL_ONES;
      OP_ROL, OP_ROR: return FILL_COPY;
      default:        return FILL_ZERO;
    endcase
  endfunction

endpackage

// File: rtl/ssr_bitrev.sv
module ssr_bitrev #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] in_i,
  output logic [W-1:0] out_o
);

  for (genvar i = 0; i < W; i++) begin : g_mirror
    assign out_o[i] = in_i[W-1-i];
  end

endmodule

// File: rtl/ssr_byte_ops.sv
module ssr_byte_ops #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  output logic [W-1:0] byte_mirror_o,
  output logic [W-1:0] orc_o
);

  localparam int unsigned NBYTES = W / 8;

  for (genvar k = 0; k < NBYTES; k++) begin : g_byte
    logic [7:0] lane;
    assign lane = a_i[8*k +: 8];

    // Bit order mirrored inside the lane; a following full-word
    // mirror turns this into a pure byte swap.
    for (genvar j = 0; j < 8; j++) begin : g_bit
      assign byte_mirror_o[8*k + j] = lane[7-j];
    end

    assign orc_o[8*k +: 8] = {8{|lane}};
  end

endmodule

// File: rtl/ssr_rshift.sv
module ssr_rshift #(
  parameter int unsigned W  = 32,
  parameter int unsigned SH = $clog2(W)
) (
  input  logic [2*W-1:0] data_i,
  input  logic [SH-1:0]  amt_i,
  output logic [W-1:0]   out_o
);

  localparam int unsigned WW = 2 * W;

  logic [WW-1:0] stage [SH+1];

  assign stage[0] = data_i;

  // Logarithmic stages: stage s moves by 2**s when amt_i[s] is set
  for (genvar s = 0; s < SH; s++) begin : g_stage
    assign stage[s+1] = amt_i[s] ? (stage[s] >> (1 << s)) : stage[s];
  end

  assign out_o = stage[SH][W-1:0];

  logic unused_upper;
  assign unused_upper = ^stage[SH][WW-1:W];

endmodule

// File: rtl/ssr_unit.sv
module ssr_unit #(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [3:0]      op_i,
  output logic [XLEN-1:0] result_o
);
  import ssr_pkg::*;

  localparam int unsigned SH     = $clog2(XLEN);
  localparam int unsigned NBYTES = XLEN / 8;

  ssr_op_e   op;
  ssr_fill_e fill_kind;
  logic      left_dir;
  logic      front_mirror;

  assign op           = ssr_op_e'(op_i);
  assign left_dir     = op_is_left(op);
  assign fill_kind    = op_fill(op);
  assign front_mirror = left_dir || (op == OP_REV) || (op == OP_REV8);

  // Byte-lane helpers
  logic [XLEN-1:0] byte_mirror;
  logic [XLEN-1:0] orc_word;

  ssr_byte_ops #(.W(XLEN)) u_bytes (
    .a_i           (a_i),
    .byte_mirror_o (byte_mirror),
    .orc_o         (orc_word)
  );

  // Front mirror stage, shared by left shifts, rev and rev8
  logic [XLEN-1:0] front_src;
  logic [XLEN-1:0] front_rev;

  assign front_src = (op == OP_REV8) ? byte_mirror : a_i;

  ssr_bitrev #(.W(XLEN)) u_front (
    .in_i  (front_src),
    .out_o (front_rev)
  );

  // Wide shifter input: fill pattern above, operand below
  logic [XLEN-1:0] sh_low;
  logic [XLEN-1:0] sh_high;
  logic [SH-1:0]   sh_amt;
  logic [XLEN-1:0] sh_out;

  assign sh_low = front_mirror ? front_rev : a_i;
  assign sh_amt = op_uses_amt(op) ? b_i[SH-1:0] : '0;

  always_comb begin
    case (fill_kind)
      FILL_ONES: sh_high = '1;
      FILL_SIGN: sh_high = {XLEN{a_i[XLEN-1]}};
      FILL_COPY: sh_high = sh_low;
      default:   sh_high = '0;
    endcase
  end

  ssr_rshift #(.W(XLEN), .SH(SH)) u_shift (
    .data_i ({sh_high, sh_low}),
    .amt_i  (sh_amt),
    .out_o  (sh_out)
  );

  // Back mirror stage for left-direction results
  logic [XLEN-1:0] back_rev;

  ssr_bitrev #(.W(XLEN)) u_back (
    .in_i  (sh_out),
    .out_o (back_rev)
  );

  always_comb begin
    case (op)
      OP_SLL, OP_SLO, OP_ROL:                 result_o = back_rev;
      OP_SRL, OP_SRA, OP_SRO, OP_ROR,
      OP_REV, OP_REV8:                        result_o = sh_out;
      OP_ORCB:                                result_o = orc_word;
      default:                                result_o = '0;
    endcase
  end

  logic unused_b_hi;
  assign unused_b_hi = ^b_i[XLEN-1:SH];

  // Named events for the checks below
  logic amt_nonzero;
  assign amt_nonzero = |b_i[SH-1:0];

  always_comb begin
    // R6
    zero_amt_ident_chk: assert (!(op_uses_amt(op) && !amt_nonzero) || (result_o == a_i))
      else $error("zero distance altered operand");
    // R2
    sll_lsb_zero_chk: assert (!(op == OP_SLL && amt_nonzero) || !result_o[0])
      else $error("sll fill not zero");
    // R2
    srl_msb_zero_chk: assert (!(op == OP_SRL && amt_nonzero) || !result_o[XLEN-1])
      else $error("srl fill not zero");
    // R3
    sra_sign_keep_chk: assert (!(op == OP_SRA) || (result_o[XLEN-1] == a_i[XLEN-1]))
      else $error("sra sign lost");
    // R4
    slo_lsb_one_chk: assert (!(op == OP_SLO && amt_nonzero) || result_o[0])
      else $error("slo fill not one");
    // R4
    sro_msb_one_chk: assert (!(op == OP_SRO && amt_nonzero) || result_o[XLEN-1])
      else $error("sro fill not one");
    // R5
    rot_popcount_chk: assert (!(op == OP_ROL || op == OP_ROR) ||
                              ($countones(result_o) == $countones(a_i)))
      else $error("rotate lost bits");
    // R7
    rev_ends_chk: assert (!(op == OP_REV) ||
                          (result_o[0] == a_i[XLEN-1] && result_o[XLEN-1] == a_i[0]))
      else $error("rev ends wrong");
    // R8
    rev8_popcount_chk: assert (!(op == OP_REV8) ||
                               ($countones(result_o) == $countones(a_i)))
      else $error("rev8 lost bits");
    // R9
    for (int k = 0; k < NBYTES; k++) begin
      orcb_byte_chk: assert (!(op == OP_ORCB) ||
                             (result_o[8*k +: 8] == ((a_i[8*k +: 8] != 8'h00) ? 8'hFF : 8'h00)))
        else $error("orc.b lane wrong");
    end
  end

endmodule

// File: tb/ssr_unit_bench.sv
module ssr_unit_bench;

  logic        clk = 1'b0;
  logic [31:0] a, b;
  logic [3:0]  op;
  logic [31:0] res;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  ssr_unit u_ssr_unit (
    .a_i      (a),
    .b_i      (b),
    .op_i     (op),
    .result_o (res)
  );

  // Bit-by-bit reference model
  function automatic logic [31:0] model(input logic [3:0] o,
                                        input logic [31:0] x,
                                        input logic [31:0] y);
    logic [31:0] r;
    int s;
    s = int'(y[4:0]);
    r = '0;
    for (int i = 0; i < 32; i++) begin
      case (o)
        4'd0: r[i] = (i >= s) ? x[i-s] : 1'b0;
        4'd1: r[i] = (i + s < 32) ? x[i+s] : 1'b0;
        4'd2: r[i] = (i + s < 32) ? x[i+s] : x[31];
        4'd3: r[i] = (i >= s) ? x[i-s] : 1'b1;
        4'd4: r[i] = (i + s < 32) ? x[i+s] : 1'b1;
        4'd5: r[i] = x[(i - s + 32) % 32];
        4'd6: r[i] = x[(i + s) % 32];
        4'd7: r[i] = x[31-i];
        4'd8: r[i] = x[8*(3 - i/8) + (i % 8)];
        4'd9: r[i] = (x[8*(i/8) +: 8] != 8'h00);
        default: r[i] = 1'b0;
      endcase
    end
    return r;
  endfunction

  function automatic string req_of(input logic [3:0] o, input logic [31:0] y);
    if (o <= 4'd6 && y[4:0] == 5'd0) return "R6";
    case (o)
      4'd0, 4'd1: return "R2";
      4'd2:       return "R3";
      4'd3, 4'd4: return "R4";
      4'd5, 4'd6: return "R5";
      4'd7:       return "R7";
      4'd8:       return "R8";
      4'd9:       return "R9";
      default:    return "R1";
    endcase
  endfunction

  task automatic apply_check(input logic [3:0] o, input logic [31:0] x,
                             input logic [31:0] y, input string tag);
    logic [31:0] exp;
    @(posedge clk);
    op = o; a = x; b = y;
    @(negedge clk);
    exp = model(o, x, y);
    n_chk++;
    if (res !== exp) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%h b=%h actual=%h expected=%h",
               tag, o, x, y, res, exp);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] lfsr;
    logic [31:0] pats [8];
    lfsr = 32'hACE1_2468;
    pats[0] = 32'h0000_0000;
    pats[1] = 32'hFFFF_FFFF;
    pats[2] = 32'h8000_0000;
    pats[3] = 32'h0000_0001;
    pats[4] = 32'hA5C3_1E70;
    pats[5] = 32'h7FFF_FFFF;
    pats[6] = 32'h00FF_0100;
    pats[7] = 32'h9E37_79B9;
    op = '0; a = '0; b = '0;

    // Idle state: zero operands give zero for every code (R1)
    for (int o = 0; o < 16; o++)
      apply_check(4'(o), 32'h0, 32'h0, "R1");

    // Full sweep: all codes, all distances, fixed and mixed operands
    for (int o = 0; o < 16; o++) begin
      for (int s = 0; s < 32; s++) begin
        for (int p = 0; p < 10; p++) begin
          logic [31:0] x;
          logic [31:0] junk;
          lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
          x    = (p < 8) ? pats[p] : lfsr;
          junk = {lfsr[15:0], lfsr[31:16]};
          // upper bits of b carry junk to show they are ignored (R6)
          apply_check(4'(o), x, {junk[31:5], 5'(s)},
                      req_of(4'(o), {27'h0, 5'(s)}));
        end
      end
    end

    // Byte-swap and spread corner words (R8, R9)
    apply_check(4'd8, 32'h1122_3344, 32'hFFFF_FFFF, "R8");
    apply_check(4'd9, 32'h0080_0001, 32'h0000_0000, "R9");
    apply_check(4'd9, 32'h1000_0000, 32'h0000_001F, "R9");
    apply_check(4'd7, 32'h0000_0003, 32'h0000_0011, "R7");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule